// File: doc/BRIEF.md
# Programmable AND-OR Product-Term Array

This block is the logic core of a small programmable logic device. It takes ten dedicated input signals and eight feedback signals from the I/O cells. For each signal it forms a true line and an inverted line. Every product term is a wide AND over whichever of those lines its connection bits select. Consecutive runs of product terms are ORed into eight sum outputs, and the runs have unequal lengths. The terms after the sum terms are brought out one by one as control terms: a per-output enable, a global preset, a global clear and a clock term. These feed the macrocells, which sit outside this block.

The connection map is held in a shift chain, one bit per product-term/line crossing. It is filled one bit per clock while a load strobe is high. Reset returns the chain to the erased state, in which every crossing is open. A fully open term reads TRUE. A term that takes both polarities of any one signal reads FALSE, and this is how unused terms are parked. Once the map is loaded, the whole array is combinational from its inputs to its outputs, and no clock is needed to evaluate it.

Top module: `sop_term_array`

## Requirements
- R1: The line for signal k is at index 2k for the true polarity and at 2k+1 for the inverted polarity. Signals 0 to 9 are `ded_in[0..9]` and signals 10 to 17 are `io_fb[0..7]`, which gives 36 lines.
- R2: Connection bit `t*36 + l` joins line l to product term t when it is 1. A term is the AND of all the lines connected to it.
- R3: A product term with no connected line evaluates to 1.
- R4: A product term connected to both lines of the same signal evaluates to 0, whatever the inputs are.
- R5: Terms 0 to 101 form the sums. Output 0 takes the first 8 of them, and outputs 1 to 7 take the next 10, 12, 14, 16, 16, 14 and 12 in that order. `sum_out[o]` is the OR of its group.
- R6: Term 102+o drives `oe_term[o]`. Term 110 drives `preset_term`, term 111 drives `clear_term` and term 112 drives `clock_term`.
- R7: At each rising clock edge with `load_en` high, the map moves one place toward higher indices and `cfg_in` enters bit 0. After 4068 loads, the first bit shifted in sits at bit 4067.
- R8: While `load_en` is low, the map holds its value, and `cfg_in` has no effect on any output.
- R9: A synchronous active-low reset clears every connection bit, so every output reads 1. Reset wins over `load_en`.
- R10: All outputs follow `ded_in` and `io_fb` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Load clock |
| rst_n | input | 1 | Synchronous active-low reset (erase) |
| load_en | input | 1 | Shift one map bit in per clock |
| cfg_in | input | 1 | Serial map bit |
| ded_in | input | 10 | Dedicated input signals |
| io_fb | input | 8 | Feedback signals from the I/O cells |
| sum_out | output | 8 | OR of each output's term group |
| oe_term | output | 8 | Per-output enable terms |
| preset_term | output | 1 | Global preset term |
| clear_term | output | 1 | Global clear term |
| clock_term | output | 1 | Clock term |

## Verification
The bench builds the block with its default parameters: ten dedicated signals, eight feedback signals, and a group ramp that starts at 8 and steps by 2. This gives the full 113-term, 4068-bit map. At that size a complete serial load takes about four thousand cycles, so the bench can afford several whole maps. These include random maps that mix open, self-cancelling and sparse terms, and a directed map that places single live terms at the edges of the groups (terms 7, 8 and 101). A one-bit extra shift after a full load shows the direction of the chain. A reset held together with the load strobe shows that the erase takes priority.

// File: rtl/sop_array_pkg.sv
// Package: shared constants and group-size arithmetic for the product-term array.
// Assumes the sum groups ramp up by a fixed step to the middle output, then fall back.
package sop_array_pkg;

    localparam int DEF_N_DED    = 10;
    localparam int DEF_N_FB     = 8;
    localparam int DEF_GRP_BASE = 8;
    localparam int DEF_GRP_STEP = 2;
    localparam int N_CTRL_GLOB  = 3;   // preset, clear, clock

    // Ramp position of output o: rises to n_out/2, then mirrors back down.
    function automatic int grp_rank(input int o, input int n_out);
        int hi;
        hi = n_out + 1 - o;
        if (o < n_out / 2)
            return o;
        return (hi < n_out / 2) ? hi : n_out / 2;
    endfunction

    // Number of sum terms feeding output o.
    function automatic int grp_size(input int o, input int n_out, input int base, input int step);
        return base + step * grp_rank(o, n_out);
    endfunction

    // Index of the first sum term of output o (also the total when o == n_out).
    function automatic int grp_first(input int o, input int n_out, input int base, input int step);
        int acc;
        acc = 0;
        for (int i = 0; i < o; i++)
            acc += grp_size(i, n_out, base, step);
        return acc;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
// Module: serial connection-map chain.
// Shifts cfg_in into bit 0 on each enabled clock, moving older bits upward.
// Assumes a synchronous active-low reset that erases the map (all bits open).
module sop_cfg_chain #(
    parameter int N_BITS = 4068
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              cfg_in,
    output logic [N_BITS-1:0] map_q
);

    // Erase on reset, otherwise shift one bit when loading.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_q <= '0;
        else if (load_en)
            map_q <= {map_q[N_BITS-2:0], cfg_in};
    end

endmodule

// File: rtl/sop_line_gen.sv
// Module: input line generator.
// Builds the true and inverted line of every signal, dedicated inputs first.
// Assumes the line pair of signal k sits at 2k (true) and 2k+1 (inverted).
module sop_line_gen #(
    parameter int N_DED = 10,
    parameter int N_FB  = 8,
    localparam int N_SIG  = N_DED + N_FB,
    localparam int N_LINE = 2 * N_SIG
) (
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   io_fb,
    output logic [N_LINE-1:0] lines
);

    logic [N_SIG-1:0] sig;

    // Concatenate signals with dedicated inputs at the low indices.
    assign sig = {io_fb, ded_in};

    for (genvar k = 0; k < N_SIG; k++) begin : g_pair
        // Drive the true and inverted line of signal k.
        assign lines[2*k]   = sig[k];
        assign lines[2*k+1] = ~sig[k];
    end

endmodule

// File: rtl/sop_and_plane.sv
// Module: programmable AND plane.
// Each term is the AND of the lines whose connection bit is set.
// Assumes an open bit removes the line (the term then reads TRUE when fully open).
module sop_and_plane #(
    parameter int N_LINE = 36,
    parameter int N_TERM = 113,
    localparam int N_BITS = N_LINE * N_TERM
) (
    input  logic [N_LINE-1:0] lines,
    input  logic [N_BITS-1:0] map_q,
    output logic [N_TERM-1:0] pterm
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // An open crossing forces a 1 into the AND; a closed one passes the line.
        assign pterm[t] = &(lines | ~map_q[t*N_LINE +: N_LINE]);
    end

endmodule

// File: rtl/sop_or_plane.sv
// Module: fixed OR plane.
// ORs consecutive runs of sum terms into one output each; run sizes come from the package ramp.
// Assumes the sum terms are numbered from output 0 upward with no gaps.
module sop_or_plane
    import sop_array_pkg::*;
#(
    parameter int N_OUT    = 8,
    parameter int GRP_BASE = 8,
    parameter int GRP_STEP = 2,
    localparam int N_SUM = grp_first(N_OUT, N_OUT, GRP_BASE, GRP_STEP)
) (
    input  logic [N_SUM-1:0] sum_terms,
    output logic [N_OUT-1:0] sum_out
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        localparam int FIRST = grp_first(o, N_OUT, GRP_BASE, GRP_STEP);
        localparam int SIZE  = grp_size(o, N_OUT, GRP_BASE, GRP_STEP);
        // Collapse this output's run of terms.
        assign sum_out[o] = |sum_terms[FIRST +: SIZE];
    end

endmodule

// File: rtl/sop_term_array.sv
// Module: top of the programmable AND-OR product-term array.
// Term order: all sum terms, then one enable per output, then preset, clear, clock.
// Assumes the number of outputs equals the number of feedback signals.
module sop_term_array
    import sop_array_pkg::*;
#(
    parameter int N_DED    = DEF_N_DED,
    parameter int N_FB     = DEF_N_FB,
    parameter int GRP_BASE = DEF_GRP_BASE,
    parameter int GRP_STEP = DEF_GRP_STEP,
    localparam int N_OUT  = N_FB,
    localparam int N_LINE = 2 * (N_DED + N_FB),
    localparam int N_SUM  = grp_first(N_OUT, N_OUT, GRP_BASE, GRP_STEP),
    localparam int N_TERM = N_SUM + N_OUT + N_CTRL_GLOB,
    localparam int N_BITS = N_TERM * N_LINE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cfg_in,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  io_fb,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_term,
    output logic             preset_term,
    output logic             clear_term,
    output logic             clock_term
);

    localparam int OE_BASE  = N_SUM;
    localparam int GLB_BASE = N_SUM + N_OUT;

    logic [N_BITS-1:0] fuse_map;
    logic [N_LINE-1:0] lines;
    logic [N_TERM-1:0] pterm;

    sop_cfg_chain #(.N_BITS(N_BITS)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .cfg_in  (cfg_in),
        .map_q   (fuse_map)
    );

    sop_line_gen #(.N_DED(N_DED), .N_FB(N_FB)) u_lines (
        .ded_in (ded_in),
        .io_fb  (io_fb),
        .lines  (lines)
    );

    sop_and_plane #(.N_LINE(N_LINE), .N_TERM(N_TERM)) u_and (
        .lines (lines),
        .map_q (fuse_map),
        .pterm (pterm)
    );

    sop_or_plane #(.N_OUT(N_OUT), .GRP_BASE(GRP_BASE), .GRP_STEP(GRP_STEP)) u_or (
        .sum_terms (pterm[N_SUM-1:0]),
        .sum_out   (sum_out)
    );

    // Route the dedicated control terms straight out.
    assign oe_term     = pterm[OE_BASE +: N_OUT];
    assign preset_term = pterm[GLB_BASE];
    assign clear_term  = pterm[GLB_BASE + 1];
    assign clock_term  = pterm[GLB_BASE + 2];

endmodule

// File: rtl/sop_term_array_chk.sv
// Module: assertion checker for sop_term_array, attached by bind below.
// Assumes it sees the connection map and the raw term vector of the top.
module sop_term_array_chk #(
    parameter int N_DED  = 10,
    parameter int N_FB   = 8,
    parameter int N_LINE = 36,
    parameter int N_TERM = 113,
    localparam int N_BITS = N_LINE * N_TERM
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic              cfg_in,
    input logic [N_DED-1:0]  ded_in,
    input logic [N_FB-1:0]   io_fb,
    input logic [N_FB-1:0]   sum_out,
    input logic [N_FB-1:0]   oe_term,
    input logic              preset_term,
    input logic              clear_term,
    input logic              clock_term,
    input logic [N_BITS-1:0] fuse_map,
    input logic [N_TERM-1:0] pterm
);

    logic [2*N_FB+2:0] outs;
    assign outs = {sum_out, oe_term, preset_term, clear_term, clock_term};

    // Reset erases the map and every output reads 1 (R9).
    assert_reset_erase_R9: assert property (@(posedge clk)
        !rst_n |=> (fuse_map == '0) && (&outs));

    // A load shifts the map up and takes cfg_in at bit 0 (R7).
    assert_shift_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (fuse_map[0] == $past(cfg_in))
                    && (fuse_map[N_BITS-1:1] == $past(fuse_map[N_BITS-2:0])));

    // Without load the map holds (R8).
    assert_map_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(fuse_map));

    // Held map and held inputs give held outputs (R8, R10).
    assert_out_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_en) && $stable(ded_in) && $stable(io_fb)) |-> $stable(outs));

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_LINE/2-1:0] clash;
        for (genvar s = 0; s < N_LINE/2; s++) begin : g_sig
            assign clash[s] = fuse_map[t*N_LINE + 2*s] & fuse_map[t*N_LINE + 2*s + 1];
        end

        // Fully open term reads TRUE (R3).
        assert_open_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (fuse_map[t*N_LINE +: N_LINE] == '0) |-> pterm[t]);

        // Both polarities of one signal force FALSE (R4).
        assert_clash_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (|clash) |-> !pterm[t]);
    end

endmodule

bind sop_term_array sop_term_array_chk #(
    .N_DED  (N_DED),
    .N_FB   (N_FB),
    .N_LINE (N_LINE),
    .N_TERM (N_TERM)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .cfg_in      (cfg_in),
    .ded_in      (ded_in),
    .io_fb       (io_fb),
    .sum_out     (sum_out),
    .oe_term     (oe_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .clock_term  (clock_term),
    .fuse_map    (fuse_map),
    .pterm       (pterm)
);

// File: tb/sim_sop_term_array.sv
// Bench for sop_term_array: seeded random maps and inputs plus directed corner maps,
// compared against a model written from the requirements.
module sim_sop_term_array;

    localparam int NL = 36;
    localparam int NT = 113;
    localparam int NB = NL * NT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic [9:0] ded_in = '0;
    logic [7:0] io_fb = '0;
    logic [7:0] sum_out, oe_term;
    logic       preset_term, clear_term, clock_term;

    int errors = 0;
    int checks = 0;
    logic [NB-1:0] mdl;
    int grp[8] = '{8, 10, 12, 14, 16, 16, 14, 12};

    always #5 clk = ~clk;

    sop_term_array u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_in(cfg_in),
        .ded_in(ded_in), .io_fb(io_fb), .sum_out(sum_out), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term), .clock_term(clock_term)
    );

    // R1, R2: value of term t from the model map.
    function automatic bit m_term(int t);
        for (int l = 0; l < NL; l++) begin
            int  k = l / 2;
            bit  v = (k < 10) ? ded_in[k] : io_fb[k-10];
            bit  ln = (l % 2) ? ~v : v;
            if (mdl[t*NL + l] && !ln) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R5: OR of each output's group.
    function automatic logic [7:0] m_sum();
        logic [7:0] r = '0;
        int base = 0;
        for (int o = 0; o < 8; o++) begin
            for (int j = 0; j < grp[o]; j++) r[o] |= m_term(base + j);
            base += grp[o];
        end
        return r;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R5, R6, R10: compare every output against the model.
    task automatic chk_all(string tag);
        logic [7:0] oe_e;
        for (int o = 0; o < 8; o++) oe_e[o] = m_term(102 + o);
        chk({tag, " R5 sums"}, sum_out, m_sum());
        chk({tag, " R6 enables"}, oe_term, oe_e);
        chk({tag, " R6 globals"}, {5'd0, preset_term, clear_term, clock_term},
            {5'd0, m_term(110), m_term(111), m_term(112)});
    endtask

    // R10: new inputs seen with no clock edge in between.
    task automatic apply(logic [9:0] d, logic [7:0] f, string tag);
        @(negedge clk);
        ded_in = d; io_fb = f;
        #1;
        chk_all(tag);
    endtask

    // R7: shift the model map in, highest index first.
    task automatic load_map();
        for (int i = NB - 1; i >= 0; i--) begin
            @(negedge clk);
            load_en = 1'b1; cfg_in = mdl[i];
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Random map: open, self-cancelling and sparse terms mixed.
    task automatic rand_map(int open_w);
        mdl = '0;
        for (int t = 0; t < NT; t++) begin
            int r = $urandom % 16;
            if (r < open_w) begin
                // leave open (R3)
            end else if (r < 8) begin
                int s = $urandom % 18;
                mdl[t*NL + 2*s] = 1'b1; mdl[t*NL + 2*s + 1] = 1'b1;   // R4
            end else begin
                int n = 1 + $urandom % 3;
                for (int j = 0; j < n; j++) mdl[t*NL + ($urandom % NL)] = 1'b1;
            end
        end
    endtask

    task automatic run_all();
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: erased after reset, all outputs 1.
        chk("R9 reset sums", sum_out, 8'hFF);
        chk("R9 reset enables", oe_term, 8'hFF);
        chk("R9 reset globals", {5'd0, preset_term, clear_term, clock_term}, 8'h07);

        // Random maps under random inputs (R1, R2, R3, R4, R5, R6, R10).
        for (int m = 0; m < 2; m++) begin
            rand_map(m == 0 ? 2 : 0);
            load_map();
            for (int v = 0; v < 60; v++)
                apply(10'($urandom), 8'($urandom), "rand");
            // R8: cfg_in toggling without load_en changes nothing.
            for (int c = 0; c < 20; c++) begin
                @(negedge clk); cfg_in = ~cfg_in;
            end
            #1;
            chk_all("R8 hold");
        end

        // Directed map: every term parked (R4) except a few at group edges.
        mdl = '1;
        mdl[7*NL +: NL]   = '0;            // term 7, last of output 0, open (R3)
        mdl[8*NL +: NL]   = '0;
        mdl[8*NL + 0]     = 1'b1;          // term 8, first of output 1 = ded_in[0]
        mdl[101*NL +: NL] = '0;
        mdl[101*NL + 35]  = 1'b1;          // term 101, last of output 7 = ~io_fb[7]
        mdl[105*NL +: NL] = '0;            // enable of output 3 open
        mdl[110*NL +: NL] = '0;
        mdl[110*NL + 18]  = 1'b1;          // preset = ded_in[9]
        load_map();
        apply(10'h001, 8'h00, "dir");
        chk("R5 edges a", sum_out, 8'b1000_0011);
        chk("R6 enable 3", oe_term, 8'b0000_1000);
        apply(10'h200, 8'h80, "dir");
        chk("R5 edges b", sum_out, 8'b0000_0001);
        chk("R6 preset", {5'd0, preset_term, clear_term, clock_term}, 8'b0000_0100);

        // R7: one more shift moves every bit up by one place.
        @(negedge clk); load_en = 1'b1; cfg_in = 1'b0;
        @(negedge clk); load_en = 1'b0;
        mdl = {mdl[NB-2:0], 1'b0};
        apply(10'h001, 8'h00, "R7 shift");
        apply(10'h3FF, 8'hFF, "R7 shift");

        // R9: reset together with load_en still erases.
        @(negedge clk); rst_n = 1'b0; load_en = 1'b1; cfg_in = 1'b1;
        @(negedge clk); rst_n = 1'b1; load_en = 1'b0;
        #1;
        chk("R9 reset over load", sum_out & oe_term, 8'hFF);
        chk("R9 reset over load globals", {5'd0, preset_term, clear_term, clock_term}, 8'h07);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule